// File: doc/BRIEF.md
# Multi-Channel Register-Programmed PWM Bank

This block is a pulse-width-modulation peripheral with several independent channels. Software programs it over a simple synchronous register bus. A write strobe, a byte address and a 32-bit write word are sampled on the rising clock edge. The read word is combinational from the address. One shared register at address zero holds a bitmap of channel enables. Each channel has its own small window of registers. In that window, a control word holds a PWM-mode bit and a power-of-two divider exponent. A period register and a threshold register sit at fixed offsets in the same window.

Each channel divides the system clock by 2^N to make a tick. On every tick a counter advances from zero to period minus one and then wraps. The channel output is high while the counter is below the threshold. Software can write new settings at any time. They are held in shadow registers and move into the running copy only at a period boundary, so a pulse is never cut short or stretched. Clearing a channel's enable bit or its mode bit stops the channel at once. The output drops low and the counter and divider restart from zero.

Top module: `pwm_bank`

## Requirements
- R1: The register at byte address 0x000 is the enable bitmap. Bit i enables channel i. Bits at or above the channel count read back as zero, and bit i reads back as last written.
- R2: The channel windows start at byte addresses 0x010, 0x050, 0x090, 0x0D0, 0x110, 0x150, 0x190 and 0x220, for channels 0 to 7. The control word sits at window offset 0x00, with the PWM-mode bit at bit 15 and the divider exponent N in bits 2:0. The 13-bit period sits at offset 0x2C and the 13-bit threshold at offset 0x30, both in bits 12:0. Each reads back as stored, with all other bits zero.
- R3: A read of any address that is not a mapped register returns zero. A write to such an address changes no register.
- R4: A running channel's counter advances once every 2^N clock cycles, where N is the active divider exponent (0 to 7).
- R5: A running channel counts from 0 to P-1 and then wraps to 0. A period P of 0 behaves like a period of 1. The output is high exactly while the counter is below the threshold T. In the first cycle after the edge that starts a channel, the counter is 0.
- R6: A threshold of zero gives a constant-low output. A threshold at or above a nonzero period gives a constant-high output.
- R7: A channel runs only while its enable bit and its mode bit are both 1. When either is cleared, the output is low from the next cycle and the counter and divider return to zero. A restart therefore begins a fresh period.
- R8: A period, threshold or divider written while a channel runs takes effect only when the current period ends.
- R9: Channels run independently. Running one channel never changes the output of another.
- R10: Synchronous active-high reset clears every register and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte address for a read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM waveform per channel |

## Verification
A running copy of the settings that is wrong, or loaded at the wrong moment, shows on the channel pin within one period. The pulse width or the period length then departs from the programmed values, or changes partway through a period. A counter or divider left uncleared after a stop shows as a phase shift in the first period after the restart. So every waveform window starts at a known edge and compares each cycle against a cycle-exact model. Decode faults show at once on the read port as a wrong or nonzero word, or later as a channel that runs with settings it was never given.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int DATA_W    = 32;
    localparam int PER_W     = 13;
    localparam int DIV_W     = 3;
    localparam int PRE_W     = (1 << DIV_W) - 1;
    localparam int MODE_BIT  = 15;

    localparam int EN_ADDR   = 'h000;
    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_PER   = 'h02C;
    localparam int OFS_THR   = 'h030;

    localparam int WIN_FIRST = 'h010;
    localparam int WIN_STEP  = 'h040;
    localparam int WIN_SPLIT = 7;
    localparam int WIN_HIGH  = 'h220;

    typedef struct packed {
        logic             mode;
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] thr;
    } chan_cfg_t;

    // Byte address of a channel window; the windows after the split jump upward.
    function automatic int win_base(input int ch);
        if (ch < WIN_SPLIT)
            return WIN_FIRST + ch * WIN_STEP;
        return WIN_HIGH + (ch - WIN_SPLIT) * WIN_STEP;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input chan_cfg_t c);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[MODE_BIT]     = c.mode;
        w[DIV_W-1:0]    = c.div;
        return w;
    endfunction

    function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_W-1:0] d);
        return PRE_W'((1 << d) - 1);
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_CH-1:0]        en_q,
    output chan_cfg_t [NUM_CH-1:0]   cfg_q
);

    logic              hit_en;
    logic [NUM_CH-1:0] hit_ctrl;
    logic [NUM_CH-1:0] hit_per;
    logic [NUM_CH-1:0] hit_thr;

    assign hit_en = (addr == ADDR_W'(EN_ADDR));

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en && hit_en)
            en_q <= wdata[NUM_CH-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_win
        localparam int BASE = win_base(i);
        chan_cfg_t cfg_r;

        assign hit_ctrl[i] = (addr == ADDR_W'(BASE + OFS_CTRL));
        assign hit_per[i]  = (addr == ADDR_W'(BASE + OFS_PER));
        assign hit_thr[i]  = (addr == ADDR_W'(BASE + OFS_THR));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r <= '0;
            end else if (wr_en) begin
                if (hit_ctrl[i]) begin
                    cfg_r.mode <= wdata[MODE_BIT];
                    cfg_r.div  <= wdata[DIV_W-1:0];
                end
                if (hit_per[i])
                    cfg_r.per <= wdata[PER_W-1:0];
                if (hit_thr[i])
                    cfg_r.thr <= wdata[PER_W-1:0];
            end
        end

        assign cfg_q[i] = cfg_r;
    end

    always_comb begin
        rdata = hit_en ? DATA_W'(en_q) : '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ctrl[i]) rdata = rdata | ctrl_word(cfg_q[i]);
            if (hit_per[i])  rdata = rdata | DATA_W'(cfg_q[i].per);
            if (hit_thr[i])  rdata = rdata | DATA_W'(cfg_q[i].thr);
        end
    end

endmodule

// File: rtl/pwm_bank_prescale.sv
module pwm_bank_prescale
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == div_mask(div));

    always_ff @(posedge clk) begin
        if (rst || clr)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  chan_cfg_t        cfg,
    output logic             pwm,
    output logic [PER_W-1:0] cnt,
    output chan_cfg_t        act
);

    logic tick;
    logic wrap;

    pwm_bank_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (!run),
        .div  (act.div),
        .tick (tick)
    );

    // Last count of the period; a zero period wraps every tick.
    assign wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, act.per};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            act <= '0;
        end else if (!run) begin
            cnt <= '0;
            act <= cfg;
        end else if (tick) begin
            if (wrap) begin
                cnt <= '0;
                act <= cfg;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pwm = run && (cnt < act.thr);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]             en_q;
    logic [NUM_CH-1:0]             run;
    chan_cfg_t [NUM_CH-1:0]        cfg_q;
    chan_cfg_t [NUM_CH-1:0]        act_q;
    logic [NUM_CH-1:0][PER_W-1:0]  cnt_q;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .en_q  (en_q),
        .cfg_q (cfg_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign run[i] = en_q[i] & cfg_q[i].mode;

        pwm_bank_chan u_chan (
            .clk (clk),
            .rst (rst),
            .run (run[i]),
            .cfg (cfg_q[i]),
            .pwm (pwm_out[i]),
            .cnt (cnt_q[i]),
            .act (act_q[i])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CH-1:0]             run,
    input logic [NUM_CH-1:0]             pwm,
    input logic [NUM_CH-1:0][PER_W-1:0]  cnt,
    input chan_cfg_t [NUM_CH-1:0]        act
);

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> pwm == '0); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
            !run[i] |-> !pwm[i]); // R7
        AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
            !run[i] |=> cnt[i] == '0); // R7
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            run[i] |-> (cnt[i] == '0 || cnt[i] < act[i].per)); // R5
        AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
            act[i].thr == '0 |-> !pwm[i]); // R6
        AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
            (run[i] && act[i].per != '0 && act[i].thr >= act[i].per) |-> pwm[i]); // R6
        AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
            cnt[i] != '0 |-> ($stable(act[i].per) && $stable(act[i].thr) && $stable(act[i].div))); // R8
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk (clk),
    .rst (rst),
    .run (run),
    .pwm (pwm_out),
    .cnt (cnt_q),
    .act (act_q)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(12)) u_pwm_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    typedef struct packed {
        logic [3:0]  ch;
        logic [2:0]  div;
        logic [12:0] per;
        logic [12:0] thr;
    } vec_t;

    // channel, divider exponent, period, threshold
    localparam vec_t VEC [8] = '{
        '{4'd0, 3'd0, 13'd4,  13'd1},
        '{4'd1, 3'd0, 13'd10, 13'd5},
        '{4'd2, 3'd1, 13'd6,  13'd3},
        '{4'd3, 3'd2, 13'd5,  13'd5},
        '{4'd4, 3'd0, 13'd8,  13'd0},
        '{4'd5, 3'd3, 13'd3,  13'd2},
        '{4'd6, 3'd0, 13'd7,  13'd9},
        '{4'd7, 3'd1, 13'd1,  13'd1}
    };

    function automatic int base_of(input int ch);
        return (ch < 7) ? ('h010 + 'h040 * ch) : ('h220 + 'h040 * (ch - 7));
    endfunction

    function automatic logic exp_out(input int k, input int div, input int per, input int thr);
        int p;
        p = (per == 0) ? 1 : per;
        return ((k >> div) % p) < thr;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = 12'(a);
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 12'(a);
        #1;
        d = bus_rdata;
    endtask

    // Samples one channel from cycle k0 for n cycles; optionally requires the rest low.
    task automatic watch(input int ch, input int div, input int per, input int thr,
                         input int k0, input int n, input bit others_low, output int errs);
        errs = 0;
        for (int k = k0; k < k0 + n; k++) begin
            if (pwm_out[ch] !== exp_out(k, div, per, thr)) errs++;
            if (others_low && ((pwm_out & ~(NCH'(1) << ch)) !== '0)) errs++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        logic [31:0] r3;
        int errs;
        int b;
        vec_t t;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(0, r);             check("R10 enable after reset", r, 0);
        check("R10 outputs after reset", 32'(pwm_out), 0);
        rd(base_of(7) + 'h2C, r); check("R10 period after reset", r, 0);

        // R1 enable bitmap width
        @(negedge clk);
        wr(0, 32'hFFFF_FFFF);
        rd(0, r);             check("R1 enable readback", r, 32'h0000_00FF);
        check("R1 R7 mode clear keeps outputs low", 32'(pwm_out), 0);
        @(negedge clk);
        wr(0, 0);

        // R2 field masking
        wr(base_of(0), 32'hFFFF_FFFF);
        wr(base_of(0) + 'h2C, 32'hFFFF_FFFF);
        wr(base_of(0) + 'h30, 32'hFFFF_0000);
        rd(base_of(0), r);          check("R2 control fields", r, 32'h0000_8007);
        rd(base_of(0) + 'h2C, r);   check("R2 period field", r, 32'h0000_1FFF);
        rd(base_of(0) + 'h30, r);   check("R2 threshold field", r, 32'h0000_0000);

        // R3 unmapped addresses
        @(negedge clk);
        wr('h004, 32'h0000_1234);
        wr(base_of(0) + 'h28, 32'h0000_0055);
        rd('h004, r);               check("R3 unmapped 0x004", r, 0);
        rd(base_of(0) + 'h28, r);   check("R3 unmapped window gap", r, 0);
        rd('h200, r);               check("R3 unmapped 0x200", r, 0);
        rd(base_of(0) + 'h2C, r);   check("R3 period untouched", r, 32'h0000_1FFF);
        rd(0, r);                   check("R3 enable untouched", r, 0);

        // Table of vectors: R2 readback, R4 R5 R6 waveform
        for (int v = 0; v < 8; v++) begin
            t = VEC[v];
            b = base_of(int'(t.ch));
            @(negedge clk);
            wr(0, 0);
            wr(b, 32'h8000 | 32'(t.div));
            wr(b + 'h2C, 32'(t.per));
            wr(b + 'h30, 32'(t.thr));
            rd(b, r);
            rd(b + 'h2C, r2);
            rd(b + 'h30, r3);
            check("R2 vector control readback", r, 32'h8000 | 32'(t.div));
            check("R2 vector period readback", r2, 32'(t.per));
            check("R2 vector threshold readback", r3, 32'(t.thr));
            @(negedge clk);
            wr(0, 32'(1) << t.ch);
            watch(int'(t.ch), int'(t.div), int'(t.per), int'(t.thr), 0,
                  3 * int'(t.per) * (1 << t.div) + 2, 1'b1, errs);
            check("R4 R5 R6 vector waveform mismatches", 32'(errs), 0);
        end

        // R7 stop mid-period by enable, then restart from a fresh period
        @(negedge clk);
        wr(0, 0);
        wr(base_of(0), 32'h0000_8000);
        wr(base_of(0) + 'h2C, 4);
        wr(base_of(0) + 'h30, 2);
        wr(0, 1);
        watch(0, 0, 4, 2, 0, 6, 1'b1, errs);
        wr(0, 0);
        errs = 0;
        for (int k = 0; k < 8; k++) begin
            if (pwm_out !== '0) errs++;
            @(negedge clk);
        end
        check("R7 low after enable cleared", 32'(errs), 0);
        wr(0, 1);
        watch(0, 0, 4, 2, 0, 8, 1'b1, errs);
        check("R7 restart after enable begins at count 0", 32'(errs), 0);

        // R7 stop by mode bit
        wr(base_of(0), 32'h0000_0000);
        errs = 0;
        for (int k = 0; k < 8; k++) begin
            if (pwm_out !== '0) errs++;
            @(negedge clk);
        end
        check("R7 low after mode bit cleared", 32'(errs), 0);
        wr(base_of(0), 32'h0000_8000);
        watch(0, 0, 4, 2, 0, 8, 1'b1, errs);
        check("R7 restart after mode bit begins at count 0", 32'(errs), 0);

        // R8 updates wait for the period boundary
        wr(0, 0);
        wr(base_of(2), 32'h0000_8000);
        wr(base_of(2) + 'h2C, 8);
        wr(base_of(2) + 'h30, 2);
        wr(0, 32'h4);
        watch(2, 0, 8, 2, 0, 2, 1'b1, errs);
        wr(base_of(2) + 'h2C, 4);
        wr(base_of(2) + 'h30, 3);
        errs = 0;
        for (int k = 4; k < 24; k++) begin
            if (pwm_out[2] !== ((k < 8) ? exp_out(k, 0, 8, 2) : exp_out(k - 8, 0, 4, 3))) errs++;
            @(negedge clk);
        end
        check("R8 new period and threshold at boundary", 32'(errs), 0);

        // R9 two channels at once
        wr(0, 0);
        wr(base_of(1), 32'h0000_8000);
        wr(base_of(1) + 'h2C, 5);
        wr(base_of(1) + 'h30, 2);
        wr(base_of(6), 32'h0000_8001);
        wr(base_of(6) + 'h2C, 3);
        wr(base_of(6) + 'h30, 1);
        wr(0, 32'h42);
        errs = 0;
        for (int k = 0; k < 30; k++) begin
            if (pwm_out[1] !== exp_out(k, 0, 5, 2)) errs++;
            if (pwm_out[6] !== exp_out(k, 1, 3, 1)) errs++;
            if ((pwm_out & 8'hBD) !== '0) errs++;
            @(negedge clk);
        end
        check("R9 independent channels", 32'(errs), 0);

        // R10 reset while running
        rst = 1'b1;
        @(negedge clk);
        check("R10 outputs low in reset", 32'(pwm_out), 0);
        rst = 1'b0;
        rd(0, r);                     check("R10 enable cleared by reset", r, 0);
        rd(base_of(6), r);            check("R10 control cleared by reset", r, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule